// File: doc/BRIEF.md
# Single-Cell Lithium Charge Sequencer

This block is the digital sequencing core of a single-cell lithium battery charger. It takes a set of comparator decisions that have already been turned into logic levels (supply healthy, enable, battery voltage above input, battery absent, cell too cold, cell too hot, cell above its minimum voltage, cell above its recharge level, charge current below the end-of-charge level), together with a one-cycle tick from a slow timing oscillator. From these it decides whether the charger should conduct and whether it should deliver the reduced preconditioning current or the full current. It also reports its present phase as a three-bit code.

A charge cycle always opens with a low-current preconditioning phase. The block moves to full current only once the cell has stayed above its minimum voltage for a run of consecutive oscillator ticks. A safety timer bounds the full-current phase, and a separate bound of one eighth of that limit applies to preconditioning. The full-current limit can be switched off with an input, but the preconditioning bound cannot. A timer expiry is a sticky fault that only a supply loss or an enable low-then-high sequence clears. A finished cell is recharged once it sags below the recharge level. A temperature excursion pauses charging and restarts the cycle when it clears. All comparator inputs pass through two-flop synchronisers. The oscillator tick is expected to be synchronous to the clock.

Top module: `chg_seq_ctrl`

## Requirements
- R1: While reset is asserted the state code is 0 (idle), and `chg_on` and `fast_sel` are 0. State codes are: 0 idle, 1 precondition, 2 full current, 3 complete, 4 temperature fault, 5 timeout fault.
- R2: If the supply is not healthy, enable is low, the battery is above the input, or the battery is absent, the block enters idle (code 0) with `chg_on` low, whatever state it was in.
- R3: Leaving idle with no latched timeout always enters precondition (code 1), with `chg_on` high and `fast_sel` low.
- R4: Precondition moves to full current (code 2, `fast_sel` high) only after `bat_min_ok` has been high for QUAL_TICKS consecutive ticks (15 by default). A low `bat_min_ok` restarts that count.
- R5: If precondition lasts 2^(TIMER_BITS-3) ticks without qualifying, the block enters timeout fault (code 5, `chg_on` low). This holds even when `tmo_en` is low.
- R6: Timeout fault is latched. After a forced idle that did not involve supply loss or enable low, the block returns to code 5. Enable low followed by enable high starts a fresh precondition.
- R7: With `tmo_en` high, full current that lasts 2^TIMER_BITS ticks after entering it ends in timeout fault (code 5).
- R8: With `tmo_en` low, full current is never ended by the timer.
- R9: In full current, `bat_rech_ok` and `ichg_low` both high lead to complete (code 3, `chg_on` low). In complete, `bat_rech_ok` low starts a new precondition.
- R10: `temp_cold` or `temp_hot` during precondition or full current leads to temperature fault (code 4, `chg_on` low). When both clear, a new precondition starts.
- R11: Every new precondition starts its time bound from zero, so time spent before a temperature fault does not count against the new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle timing tick, synchronous to clk |
| sup_ok | input | 1 | Supply above power-on level |
| en | input | 1 | Charger enable |
| bat_gt_in | input | 1 | Battery voltage above input |
| bat_rmv | input | 1 | Battery absent |
| temp_cold | input | 1 | Cell below low temperature limit |
| temp_hot | input | 1 | Cell above high temperature limit |
| bat_min_ok | input | 1 | Cell above minimum full-current voltage |
| bat_rech_ok | input | 1 | Cell above recharge threshold |
| ichg_low | input | 1 | Charge current below end-of-charge level |
| tmo_en | input | 1 | Full-current time limit enable |
| chg_on | output | 1 | Charger conducting |
| fast_sel | output | 1 | 1 selects full current, 0 selects preconditioning current |
| state_code | output | 3 | Present phase code |

## Verification
The hardest situations to reach are the two timer expiries. At default size they lie millions of ticks away, so the bench shrinks the timer width and drives a tick every cycle. This brings both limits within a few hundred cycles while keeping the one-eighth ratio. The restart of the qualification count and the restart of the time bound after a temperature fault are both reached by timing a flag drop so that, had no restart happened, the phase would already have changed. Forced-idle causes are picked at random from otherwise charging states.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TRKL = 3'd1,
    ST_FAST = 3'd2,
    ST_DONE = 3'd3,
    ST_TFLT = 3'd4,
    ST_TOUT = 3'd5
  } chg_state_e;

  localparam int NFLAG   = 10;
  localparam int F_SUP   = 0;
  localparam int F_EN    = 1;
  localparam int F_GTIN  = 2;
  localparam int F_RMV   = 3;
  localparam int F_COLD  = 4;
  localparam int F_HOT   = 5;
  localparam int F_MIN   = 6;
  localparam int F_RECH  = 7;
  localparam int F_ILOW  = 8;
  localparam int F_TMOEN = 9;
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/csc_qual.sv
module csc_qual #(
  parameter int QUAL_TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic ok,
  output logic qualified
);
  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] TOP = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr || !ok) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick && (cnt_q != TOP)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qualified = (cnt_q == TOP) && ok;
endmodule

// File: rtl/csc_timer.sv
module csc_timer #(
  parameter int TIMER_BITS = 22,
  parameter int TRK_SHIFT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic trk_exp,
  output logic fast_exp
);
  localparam int CW = TIMER_BITS + 1;
  localparam logic [CW-1:0] FULL    = CW'(1) << TIMER_BITS;
  localparam logic [CW-1:0] TRK_LIM = CW'(1) << (TIMER_BITS - TRK_SHIFT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run && tick && !cnt_q[TIMER_BITS]) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign trk_exp  = (cnt_q >= TRK_LIM);
  assign fast_exp = (cnt_q == FULL);
endmodule

// File: rtl/csc_fsm.sv
module csc_fsm
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flg,
  input  logic             qualified,
  input  logic             trk_exp,
  input  logic             fast_exp,
  output chg_state_e       state,
  output logic             clr_tmr,
  output logic             clr_qual
);
  chg_state_e st_q, st_d;
  logic       lat_q, lat_d;
  logic       held, tflt, eoc, lat_clr;

  assign held    = !flg[F_SUP] || !flg[F_EN] || flg[F_GTIN] || flg[F_RMV];
  assign tflt    = flg[F_COLD] || flg[F_HOT];
  assign eoc     = flg[F_RECH] && flg[F_ILOW];
  assign lat_clr = !flg[F_SUP] || !flg[F_EN];

  always_comb begin
    st_d = st_q;
    if (held) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = lat_q ? ST_TOUT : ST_TRKL;
        ST_TRKL: begin
          if (tflt)           st_d = ST_TFLT;
          else if (qualified) st_d = ST_FAST;
          else if (trk_exp)   st_d = ST_TOUT;
        end
        ST_FAST: begin
          if (tflt)                             st_d = ST_TFLT;
          else if (eoc)                         st_d = ST_DONE;
          else if (fast_exp && flg[F_TMOEN])    st_d = ST_TOUT;
        end
        ST_DONE: if (!flg[F_RECH]) st_d = ST_TRKL;
        ST_TFLT: if (!tflt)        st_d = ST_TRKL;
        ST_TOUT: st_d = ST_TOUT;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    lat_d = lat_q;
    if (lat_clr)              lat_d = 1'b0;
    else if (st_d == ST_TOUT) lat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      lat_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      lat_q <= lat_d;
    end
  end

  assign clr_tmr  = ((st_d == ST_TRKL) || (st_d == ST_FAST)) && (st_d != st_q);
  assign clr_qual = clr_tmr || (st_q != ST_TRKL);
  assign state    = st_q;
endmodule

// File: rtl/chg_seq_ctrl.sv
module chg_seq_ctrl
  import csc_pkg::*;
#(
  parameter int TIMER_BITS  = 22,
  parameter int QUAL_TICKS  = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       sup_ok,
  input  logic       en,
  input  logic       bat_gt_in,
  input  logic       bat_rmv,
  input  logic       temp_cold,
  input  logic       temp_hot,
  input  logic       bat_min_ok,
  input  logic       bat_rech_ok,
  input  logic       ichg_low,
  input  logic       tmo_en,
  output logic       chg_on,
  output logic       fast_sel,
  output logic [2:0] state_code
);
  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [NFLAG-1:0] flg_raw, flg_s;
  logic             qualified, trk_exp, fast_exp, clr_tmr, clr_qual, run;
  chg_state_e       state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    flg_raw          = '0;
    flg_raw[F_SUP]   = sup_ok;
    flg_raw[F_EN]    = en;
    flg_raw[F_GTIN]  = bat_gt_in;
    flg_raw[F_RMV]   = bat_rmv;
    flg_raw[F_COLD]  = temp_cold;
    flg_raw[F_HOT]   = temp_hot;
    flg_raw[F_MIN]   = bat_min_ok;
    flg_raw[F_RECH]  = bat_rech_ok;
    flg_raw[F_ILOW]  = ichg_low;
    flg_raw[F_TMOEN] = tmo_en;
  end

  csc_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(flg_raw), .q(flg_s)
  );

  csc_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_int_n), .clr(clr_qual), .tick(osc_tick),
    .ok(flg_s[F_MIN]), .qualified(qualified)
  );

  assign run = (state == ST_TRKL) || (state == ST_FAST);

  csc_timer #(.TIMER_BITS(TIMER_BITS), .TRK_SHIFT(3)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .clr(clr_tmr), .run(run), .tick(osc_tick),
    .trk_exp(trk_exp), .fast_exp(fast_exp)
  );

  csc_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .flg(flg_s), .qualified(qualified),
    .trk_exp(trk_exp), .fast_exp(fast_exp), .state(state),
    .clr_tmr(clr_tmr), .clr_qual(clr_qual)
  );

  assign chg_on     = run;
  assign fast_sel   = (state == ST_FAST);
  assign state_code = state;
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk
  import csc_pkg::*;
#(
  parameter int TIMER_BITS = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [NFLAG-1:0] flg,
  input logic [2:0]       state_code,
  input logic             chg_on,
  input logic             fast_sel
);
  localparam int CW = TIMER_BITS + 1;
  localparam logic [CW-1:0] TRK_BOUND = (CW'(1) << (TIMER_BITS - 3)) + CW'(2);

  logic          held;
  logic [CW-1:0] trk_ticks;

  assign held = !flg[F_SUP] || !flg[F_EN] || flg[F_GTIN] || flg[F_RMV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      trk_ticks <= '0;
    else if (state_code != 3'd1)     trk_ticks <= '0;
    else if (tick && !trk_ticks[CW-1]) trk_ticks <= trk_ticks + 1'b1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0) |-> (!chg_on && !fast_sel));

  a_r2_hold_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (state_code == 3'd0));

  a_r3_cycle_opens_trickle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_code == 3'd1 || state_code == 3'd2) && $past(state_code) == 3'd0)
      |-> (state_code == 3'd1));

  a_r4_fast_after_trickle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2 && $past(state_code) != 3'd2) |-> ($past(state_code) == 3'd1));

  a_r5_trickle_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd1) |-> (trk_ticks <= TRK_BOUND));

  a_r6_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd5 && flg[F_SUP] && flg[F_EN])
      |=> (state_code == 3'd5 || state_code == 3'd0));

  a_r9_done_from_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd3 && $past(state_code) != 3'd3) |-> ($past(state_code) == 3'd2));

  a_r10_temp_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd4)
      |=> (state_code == 3'd4 || state_code == 3'd1 || state_code == 3'd0));
endmodule

bind chg_seq_ctrl chg_seq_chk #(.TIMER_BITS(TIMER_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(osc_tick), .flg(flg_s),
  .state_code(state_code), .chg_on(chg_on), .fast_sel(fast_sel)
);

// File: tb/chg_seq_ctrl_test.sv
module chg_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TB_BITS    = 8;

  logic clk = 1'b0;
  logic rst_n, osc_tick, sup_ok, en, bat_gt_in, bat_rmv, temp_cold, temp_hot;
  logic bat_min_ok, bat_rech_ok, ichg_low, tmo_en;
  logic chg_on, fast_sel;
  logic [2:0] state_code;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  chg_seq_ctrl #(.TIMER_BITS(TB_BITS), .QUAL_TICKS(15), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sup_ok(sup_ok), .en(en),
    .bat_gt_in(bat_gt_in), .bat_rmv(bat_rmv), .temp_cold(temp_cold),
    .temp_hot(temp_hot), .bat_min_ok(bat_min_ok), .bat_rech_ok(bat_rech_ok),
    .ichg_low(ichg_low), .tmo_en(tmo_en), .chg_on(chg_on), .fast_sel(fast_sel),
    .state_code(state_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] exp_forced(input logic s, input logic e,
                                            input logic g, input logic r,
                                            input logic [2:0] other);
    if (!s || !e || g || r) return 3'd0;
    return other;
  endfunction

  function automatic logic exp_chg(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_state(input logic [2:0] exp, input string tag);
    checks++;
    if (state_code !== exp || chg_on !== exp_chg(exp) || fast_sel !== (exp == 3'd2)) begin
      errors++;
      $display("FAIL %s: state %0d chg_on %0b fast_sel %0b, expected state %0d chg_on %0b fast_sel %0b",
               tag, state_code, chg_on, fast_sel, exp, exp_chg(exp), exp == 3'd2);
    end
  endtask

  task automatic restart_cycle();
    en = 1'b0; cyc(5);
    en = 1'b1; cyc(1);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; osc_tick = 1'b1; sup_ok = 1'b1; en = 1'b1;
    bat_gt_in = 1'b0; bat_rmv = 1'b0; temp_cold = 1'b0; temp_hot = 1'b0;
    bat_min_ok = 1'b0; bat_rech_ok = 1'b0; ichg_low = 1'b0; tmo_en = 1'b1;
    cyc(3);
    chk_state(3'd0, "R1 reset");
    rst_n = 1'b1;

    // R3: first cycle opens in precondition
    cyc(8);
    chk_state(3'd1, "R3 opens trickle");

    // R2 random forcing causes
    for (int i = 0; i < 16; i++) begin
      int cause = $urandom_range(0, 3);
      sup_ok    = (cause != 0);
      en        = (cause != 1);
      bat_gt_in = (cause == 2);
      bat_rmv   = (cause == 3);
      cyc(4);
      chk_state(exp_forced(sup_ok, en, bat_gt_in, bat_rmv, 3'd1), "R2 forced idle");
      sup_ok = 1'b1; en = 1'b1; bat_gt_in = 1'b0; bat_rmv = 1'b0;
      cyc(5);
      chk_state(3'd1, "R3 resume trickle");
    end

    // R4: qualification with restart on drop
    bat_min_ok = 1'b1;
    restart_cycle();
    cyc(12);
    bat_min_ok = 1'b0; cyc(2); bat_min_ok = 1'b1;
    cyc(10);
    chk_state(3'd1, "R4 count restarted");
    cyc(16);
    chk_state(3'd2, "R4 qualified");

    // R5: precondition bound even with tmo_en low
    bat_min_ok = 1'b0; tmo_en = 1'b0;
    restart_cycle();
    cyc(27);
    chk_state(3'd1, "R5 before bound");
    cyc(17);
    chk_state(3'd5, "R5 trickle timeout");

    // R6: latch survives battery removal, cleared by enable toggle
    bat_rmv = 1'b1; cyc(5);
    chk_state(3'd0, "R2 removal idle");
    bat_rmv = 1'b0; cyc(5);
    chk_state(3'd5, "R6 latch kept");
    restart_cycle(); cyc(5);
    chk_state(3'd1, "R6 enable toggle clears");

    // R7: full-current bound with tmo_en high
    tmo_en = 1'b1; bat_min_ok = 1'b1;
    restart_cycle();
    cyc(200);
    chk_state(3'd2, "R7 before bound");
    cyc(100);
    chk_state(3'd5, "R7 fast timeout");

    // R8: no full-current bound with tmo_en low
    tmo_en = 1'b0;
    restart_cycle();
    cyc(400);
    chk_state(3'd2, "R8 timer disabled");

    // R9: completion and recharge
    bat_rech_ok = 1'b1; ichg_low = 1'b1; cyc(5);
    chk_state(3'd3, "R9 complete");
    bat_rech_ok = 1'b0; bat_min_ok = 1'b0; cyc(5);
    chk_state(3'd1, "R9 recharge");
    ichg_low = 1'b0;

    // R10: temperature faults
    temp_hot = 1'b1; cyc(5);
    chk_state(3'd4, "R10 hot fault");
    temp_hot = 1'b0; cyc(5);
    chk_state(3'd1, "R10 hot cleared");
    temp_cold = 1'b1; cyc(5);
    chk_state(3'd4, "R10 cold fault");
    temp_cold = 1'b0;

    // R11: fresh time bound after temperature fault
    restart_cycle();
    cyc(25);
    temp_hot = 1'b1; cyc(5);
    temp_hot = 1'b0; cyc(27);
    chk_state(3'd1, "R11 bound restarted");
    cyc(17);
    chk_state(3'd5, "R11 fresh bound expires");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule